// File: doc/BRIEF.md
# PCI Master Transaction Launcher

This block starts a bus-master transaction on a PCI bus when a local processor writes its launch register. The register holds the low half of the target address, a 4-bit bus command and a 2-bit burst-order field. The upper half of the address comes from a companion control register and enters as a plain input. After an accepted write the block waits until the first data phase could complete, requests the bus, and after the grant drives the full address and the command for exactly one address-phase clock.

A ready output tells the processor when the launch register may be written. It is high out of reset and drops when a write is accepted. It rises again once the address phase has been issued. Writes are accepted only while the ready output is high and the host mode field selects PCI mode. Data phases, target decoding, parity, retry and arbitration beyond request and grant are handled elsewhere.

Top module: `pci_mstr_launch`

## Requirements
- R1: A write with `reg_wr`=1 while `mar_rdy`=1 and `host_mode`=1 is accepted on that clock edge, and `mar_rdy` reads 0 from the following clock.
- R2: A write while `mar_rdy`=0 is ignored. The address, command and order of the pending transaction stay those of the accepted write.
- R3: While `host_mode` is not 1, a write is ignored. `mar_rdy` stays 1 and `req_n` stays 1.
- R4: A command with bit 0 = 1 is a write. For it, `req_n` stays 1 while `ob_empty`=1, and falls one clock after `ob_empty` is sampled 0.
- R5: A command with bit 0 = 0 is a read. For it, `req_n` stays 1 while `ib_full`=1, and falls one clock after `ib_full` is sampled 0.
- R6: One clock after `gnt_n`=0 and `bus_idle`=1 are sampled together, the address phase lasts exactly one clock. In that clock `frame_n`=0, `ad_oe`=1, `cbe_oe`=1, `ad_out`={`upper_addr`, low address} and `cbe_out`=command. In all other clocks `frame_n`=1 and both enables are 0.
- R7: During the address phase `burst_toggle`=1 only for order 2'b01 (cache-line toggle). Order 2'b00 and the reserved values 2'b10 and 2'b11 give 0 (linear incrementing).
- R8: Reset and a `soft_clr` pulse both clear the stored low 16 address bits. A pending transaction then drives 0 in `ad_out[15:0]`.
- R9: `mar_rdy` is 1 after reset and returns to 1 in the clock after the address phase.
- R10: While `gnt_n`=1 or `bus_idle`=0, `req_n` stays 0 and no address phase starts.
- R11: Launch register layout: `reg_wdata[11:8]` is the command, `[13:12]` is the burst order and `[29:14]` is the low address half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_clr | input | 1 | Software reset pulse, clears the low address bits |
| host_mode | input | 3 | Host mode field; value 1 selects PCI mode |
| upper_addr | input | 16 | Upper address half from the companion register |
| reg_wr | input | 1 | Launch register write strobe |
| reg_wdata | input | 22 | Launch register write data, bits 29:8 |
| mar_rdy | output | 1 | Launch register may be written |
| ob_empty | input | 1 | Outbound (processor-to-host) FIFO empty |
| ib_full | input | 1 | Inbound (host-to-processor) FIFO full |
| req_n | output | 1 | Bus request, active low |
| gnt_n | input | 1 | Bus grant, active low |
| bus_idle | input | 1 | Bus sampled idle (no frame, no initiator ready) |
| frame_n | output | 1 | Frame, active low, in the address phase |
| ad_out | output | 32 | Address on the multiplexed lines |
| ad_oe | output | 1 | Output enable for ad_out |
| cbe_out | output | 4 | Bus command on the command/byte-enable lines |
| cbe_oe | output | 1 | Output enable for cbe_out |
| burst_toggle | output | 1 | Burst order is cache-line toggle |

## Verification
Two events can collide in the same cycle. The first is a software clear of the low address, which can arrive while a launch is pending. The second is a stray processor write, which can arrive while the ready flag is low. The bench forces both inside the window where the block waits for FIFO space. It then checks that the address phase carries a zeroed low half, and the command and order of the first accepted write. The bench also holds a grant without an idle bus across several cycles, and checks that neither the request nor the address phase moves before both conditions are met.

// File: rtl/pml_pkg.sv
// Package: shared types and helpers for the PCI master launcher.
// Assumes: command bit 0 set marks a write-direction command.
package pml_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_REQ  = 2'd2,
        ST_ADDR = 2'd3
    } pml_state_t;

    // Order code for cache-line toggle; every other code means linear.
    localparam logic [1:0] ORDER_TOGGLE = 2'b01;

    function automatic logic is_write_cmd(input logic [3:0] cmd);
        return cmd[0];
    endfunction

    function automatic logic order_is_toggle(input logic [1:0] ord);
        return ord == ORDER_TOGGLE;
    endfunction
endpackage

// File: rtl/pml_regs.sv
// Module: launch register. It stores the low address, command and burst order.
// Assumes: the write strobe is qualified here by the ready flag and by PCI mode.
module pml_regs #(
    parameter int LO_W    = 16,
    parameter int CMD_W   = 4,
    parameter int MODE_W  = 3,
    parameter logic [MODE_W-1:0] PCI_MODE = 3'd1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                soft_clr,
    input  logic [MODE_W-1:0]   host_mode,
    input  logic                wr,
    input  logic [LO_W+CMD_W+1:0] wdata,
    input  logic                rdy,
    output logic                start,
    output logic [LO_W-1:0]     addr_lo,
    output logic [CMD_W-1:0]    cmd,
    output logic [1:0]          order
);
    localparam int ORD_LSB = CMD_W;
    localparam int LO_LSB  = CMD_W + 2;

    assign start = wr && rdy && (host_mode == PCI_MODE);

    // Low address: cleared by either reset, loaded on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) addr_lo <= '0;
        else if (start)         addr_lo <= wdata[LO_LSB +: LO_W];
    end

    // Command and order fields: loaded on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd   <= '0;
            order <= '0;
        end else if (start) begin
            cmd   <= wdata[CMD_W-1:0];
            order <= wdata[ORD_LSB +: 2];
        end
    end

    // R2
    ignored_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !start && !soft_clr) |=> ($stable(addr_lo) && $stable(cmd) && $stable(order)));
    // R8
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (addr_lo == '0));
endmodule

// File: rtl/pml_fsm.sv
// Module: launch sequencer. It waits for FIFO room, requests the bus, then issues the address phase.
// Assumes: grant is taken only when gnt_n is low and the bus is idle in the same cycle.
module pml_fsm
    import pml_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       wr_dir,
    input  logic       ob_empty,
    input  logic       ib_full,
    input  logic       gnt_n,
    input  logic       bus_idle,
    output logic       rdy,
    output logic       req_n,
    output logic       addr_phase
);
    pml_state_t state, state_nx;
    logic data_ok, granted;

    assign data_ok = wr_dir ? !ob_empty : !ib_full;
    assign granted = !gnt_n && bus_idle;

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start)   state_nx = ST_WAIT;
            ST_WAIT: if (data_ok) state_nx = ST_REQ;
            ST_REQ:  if (granted) state_nx = ST_ADDR;
            ST_ADDR:              state_nx = ST_IDLE;
            default:              state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    assign rdy        = (state == ST_IDLE);
    assign req_n      = (state != ST_REQ);
    assign addr_phase = (state == ST_ADDR);

    // R1
    accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !rdy);
    // R4 R5
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !data_ok) |=> req_n);
    // R10
    wait_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_n && !granted) |=> (!req_n && !addr_phase));
    // R9
    rdy_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_phase |=> rdy);
endmodule

// File: rtl/pml_drive.sv
// Module: address-phase driver. It places the address and command on the bus for the address phase only.
// Assumes: the upper address half is stable input from the companion register.
module pml_drive
    import pml_pkg::*;
#(
    parameter int LO_W  = 16,
    parameter int HI_W  = 16,
    parameter int CMD_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  addr_phase,
    input  logic [HI_W-1:0]       upper,
    input  logic [LO_W-1:0]       lower,
    input  logic [CMD_W-1:0]      cmd,
    input  logic [1:0]            order,
    output logic                  frame_n,
    output logic [HI_W+LO_W-1:0]  ad_out,
    output logic                  ad_oe,
    output logic [CMD_W-1:0]      cbe_out,
    output logic                  cbe_oe,
    output logic                  burst_toggle
);
    // Output mux: values only while the address phase is active.
    always_comb begin
        frame_n      = !addr_phase;
        ad_oe        = addr_phase;
        cbe_oe       = addr_phase;
        ad_out       = addr_phase ? {upper, lower} : '0;
        cbe_out      = addr_phase ? cmd : '0;
        burst_toggle = addr_phase && order_is_toggle(order);
    end

    // R6
    single_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |=> frame_n);
    // R6
    enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |-> (ad_oe && cbe_oe));
endmodule

// File: rtl/pci_mstr_launch.sv
// Module: top of the PCI master transaction launcher.
// Assumes: synchronous active-low reset. The FIFO flags and the bus inputs are synchronous to clk.
module pci_mstr_launch #(
    parameter int LO_W   = 16,
    parameter int HI_W   = 16,
    parameter int CMD_W  = 4,
    parameter int MODE_W = 3,
    parameter logic [MODE_W-1:0] PCI_MODE = 3'd1,
    localparam int WD_W  = LO_W + CMD_W + 2,
    localparam int AD_W  = LO_W + HI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic [MODE_W-1:0] host_mode,
    input  logic [HI_W-1:0]   upper_addr,
    input  logic              reg_wr,
    input  logic [WD_W+7:8]   reg_wdata,
    output logic              mar_rdy,
    input  logic              ob_empty,
    input  logic              ib_full,
    output logic              req_n,
    input  logic              gnt_n,
    input  logic              bus_idle,
    output logic              frame_n,
    output logic [AD_W-1:0]   ad_out,
    output logic              ad_oe,
    output logic [CMD_W-1:0]  cbe_out,
    output logic              cbe_oe,
    output logic              burst_toggle
);
    logic             start, addr_phase;
    logic [LO_W-1:0]  addr_lo;
    logic [CMD_W-1:0] cmd;
    logic [1:0]       order;

    pml_regs #(.LO_W(LO_W), .CMD_W(CMD_W), .MODE_W(MODE_W), .PCI_MODE(PCI_MODE)) regs_i (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .host_mode(host_mode),
        .wr(reg_wr), .wdata(reg_wdata), .rdy(mar_rdy), .start(start),
        .addr_lo(addr_lo), .cmd(cmd), .order(order)
    );

    pml_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_dir(pml_pkg::is_write_cmd(cmd)),
        .ob_empty(ob_empty), .ib_full(ib_full), .gnt_n(gnt_n), .bus_idle(bus_idle),
        .rdy(mar_rdy), .req_n(req_n), .addr_phase(addr_phase)
    );

    pml_drive #(.LO_W(LO_W), .HI_W(HI_W), .CMD_W(CMD_W)) drive_i (
        .clk(clk), .rst_n(rst_n), .addr_phase(addr_phase), .upper(upper_addr),
        .lower(addr_lo), .cmd(cmd), .order(order), .frame_n(frame_n),
        .ad_out(ad_out), .ad_oe(ad_oe), .cbe_out(cbe_out), .cbe_oe(cbe_oe),
        .burst_toggle(burst_toggle)
    );

    // R3
    non_pci_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && mar_rdy && host_mode != PCI_MODE) |=> mar_rdy);
endmodule

// File: tb/pci_mstr_launch_tb.sv
module pci_mstr_launch_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_clr = 1'b0;
    logic [2:0]  host_mode = 3'd1;
    logic [15:0] upper_addr = '0;
    logic        reg_wr = 1'b0;
    logic [29:8] reg_wdata = '0;
    logic        mar_rdy, req_n, frame_n, ad_oe, cbe_oe, burst_toggle;
    logic        ob_empty = 1'b1, ib_full = 1'b1, gnt_n = 1'b1, bus_idle = 1'b0;
    logic [31:0] ad_out;
    logic [3:0]  cbe_out;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pci_mstr_launch dut_i (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .host_mode(host_mode),
        .upper_addr(upper_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .mar_rdy(mar_rdy),
        .ob_empty(ob_empty), .ib_full(ib_full), .req_n(req_n), .gnt_n(gnt_n),
        .bus_idle(bus_idle), .frame_n(frame_n), .ad_out(ad_out), .ad_oe(ad_oe),
        .cbe_out(cbe_out), .cbe_oe(cbe_oe), .burst_toggle(burst_toggle)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R11 layout: cmd [11:8], order [13:12], low address [29:14]
    function automatic logic [29:8] pack(input logic [3:0] c, input logic [1:0] o, input logic [15:0] a);
        return {a, o, c};
    endfunction

    function automatic logic exp_toggle(input logic [1:0] o);
        return o == 2'b01;
    endfunction

    // One launch. h = cycles with the FIFO blocked, g = cycles granted but the bus busy.
    task automatic launch(input logic [3:0] c, input logic [1:0] o, input logic [15:0] lo,
                          input logic [15:0] up, input int h, input int g,
                          input bit stray, input bit sclr);
        logic [15:0] exp_lo = sclr ? 16'h0 : lo;
        if (c[0]) begin ob_empty = 1'b1; ib_full = $urandom() & 1; end
        else      begin ib_full = 1'b1;  ob_empty = $urandom() & 1; end
        upper_addr = up; gnt_n = 1'b1; bus_idle = 1'b0;
        reg_wr = 1'b1; reg_wdata = pack(c, o, lo);
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R1 rdy drops", {31'd0, mar_rdy}, 32'd0);
        chk("R4/R5 no req yet", {31'd0, req_n}, 32'd1);
        for (int i = 0; i < h; i++) begin
            if (i == 0 && stray) begin reg_wr = 1'b1; reg_wdata = pack(~c, ~o, ~lo); end
            if (i == 0 && sclr) soft_clr = 1'b1;
            @(negedge clk);
            reg_wr = 1'b0; soft_clr = 1'b0;
            chk(c[0] ? "R4 held while empty" : "R5 held while full", {31'd0, req_n}, 32'd1);
        end
        if (c[0]) ob_empty = 1'b0; else ib_full = 1'b0;
        @(negedge clk);
        chk(c[0] ? "R4 req falls" : "R5 req falls", {31'd0, req_n}, 32'd0);
        for (int i = 0; i < g; i++) begin
            gnt_n = $urandom() & 1; bus_idle = gnt_n ? ($urandom() & 1) : 1'b0;
            @(negedge clk);
            chk("R10 req held", {31'd0, req_n}, 32'd0);
            chk("R10 no frame", {31'd0, frame_n}, 32'd1);
        end
        gnt_n = 1'b0; bus_idle = 1'b1;
        @(negedge clk);
        gnt_n = 1'b1; bus_idle = 1'b0;
        chk("R6 frame", {31'd0, frame_n}, 32'd0);
        chk("R6 enables", {30'd0, ad_oe, cbe_oe}, 32'd3);
        chk(sclr ? "R8 addr" : (stray ? "R2 addr" : "R6 addr"), ad_out, {up, exp_lo});
        chk(stray ? "R2 cmd" : "R6 cmd", {28'd0, cbe_out}, {28'd0, c});
        chk("R7 order", {31'd0, burst_toggle}, {31'd0, exp_toggle(o)});
        chk("R6 req released", {31'd0, req_n}, 32'd1);
        @(negedge clk);
        chk("R6 one clock", {29'd0, frame_n, ad_oe, cbe_oe}, 32'd4);
        chk("R9 rdy back", {31'd0, mar_rdy}, 32'd1);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd5150);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset rdy", {31'd0, mar_rdy}, 32'd1);
        chk("R6 reset idle", {28'd0, req_n, frame_n, ad_oe, cbe_oe}, 32'hC);
        // R3: writes outside PCI mode are ignored
        host_mode = 3'd2; ob_empty = 1'b0; ib_full = 1'b0;
        reg_wr = 1'b1; reg_wdata = pack(4'h7, 2'b00, 16'h1234);
        @(negedge clk);
        reg_wr = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 rdy stays", {31'd0, mar_rdy}, 32'd1);
        chk("R3 no request", {31'd0, req_n}, 32'd1);
        host_mode = 3'd1;
        // directed corners: R7 with every order code, R2 stray write, R8 soft clear
        launch(4'h7, 2'b00, 16'hA5A5, 16'h8000, 2, 0, 1'b0, 1'b0);
        launch(4'h6, 2'b01, 16'h0F0F, 16'h0001, 1, 3, 1'b1, 1'b0);
        launch(4'h7, 2'b10, 16'hFFFF, 16'hFFFF, 3, 2, 1'b0, 1'b1);
        launch(4'hC, 2'b11, 16'h0001, 16'h4321, 0, 0, 1'b0, 1'b0);
        // random mix
        for (int n = 0; n < 60; n++) begin
            int h = $urandom_range(4, 0);
            launch(4'($urandom()), 2'($urandom()), 16'($urandom()), 16'($urandom()),
                   h, $urandom_range(3, 0), (h > 0) && ($urandom() & 1),
                   (h > 0) && (($urandom() & 3) == 0));
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin repeat (20000) @(posedge clk); total++; bad++; $display("FAIL watchdog expired"); end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule